// File: doc/BRIEF.md
# Threshold Interrupt with Persistence Filter

This block watches the stream of channel-0 light conversion results and raises a sticky interrupt when the light level has stayed outside a programmed window for long enough. Each time a conversion finishes, a one-cycle strobe arrives with the 16-bit result. The result is compared with a low bound and a high bound. A run counter tracks how many results in a row fell outside the window. When the run reaches the count selected by a 4-bit persistence code, a status flag is set and stays set until software issues a clear.

The persistence code is non-linear. One value bypasses the window entirely and flags every conversion. Small codes ask for one to three results in a row, and the remaining codes step up in multiples of five. The status flag always follows the filter. The active-low interrupt pin is pulled low only while an enable input is high, and is meant to drive an open-drain pad: a 0 turns the pull-down on and a 1 releases the line.

Top module: `thr_irq_filter`

## Requirements
- R1: A result is out of range when it is strictly less than the low bound or strictly greater than the high bound; a result equal to either bound is in range.
- R2: With persistence code 0 (4'b0000), every conversion strobe sets the status flag, whatever the result and the bounds.
- R3: Codes 1, 2 and 3 need 1, 2 and 3 out-of-range results in a row. Each code c from 4 to 15 needs 5*(c-3) in a row (5, 10, ... 60). The flag sets on the strobe that completes the run.
- R4: An in-range result, under any nonzero code, ends the run. A full new run is then needed before the flag sets.
- R5: Once set, the status flag stays set until the clear pulse. A clear with no strobe in the same cycle drops the flag on the next edge and zeroes the run counter.
- R6: When a clear and a strobe that meets the set condition fall in the same cycle, the flag is set. In that cycle the strobe is evaluated against the stored run count.
- R7: The status flag does not depend on the enable input. The pin irq_n is 0 exactly when the flag is 1 and the enable is 1, and is 1 otherwise.
- R8: Results and bounds are only looked at on a strobe. Changing them without a strobe changes neither the flag nor the run.
- R9: The run counter saturates at the required count. A long out-of-range run never wraps it, and while it is saturated a strobe that is out of range still sets the flag.
- R10: The flag changes on the clock edge that samples the strobe or the clear, and is visible from that edge on. Reset clears the flag and the run counter and releases the pin (irq_n = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a conversion result is ready |
| conv_value | input | 16 | Channel-0 conversion result |
| lo_bound | input | 16 | Low window bound |
| hi_bound | input | 16 | High window bound |
| pers_code | input | 4 | Persistence code |
| irq_en | input | 1 | Lets the flag drive the interrupt pin |
| irq_clr | input | 1 | One-cycle clear of the flag and the run |
| stat_flag | output | 1 | Latched interrupt status |
| irq_n | output | 1 | Active-low interrupt drive (0 pulls the pad low) |

## Verification
The window compare is swept over results from 0 to 511 against several bound pairs, including equal bounds and an empty window, using code 1. This separates a strict compare from an inclusive one, and a swapped low or high compare from a correct one. Every code from 1 to 15 is driven with runs one short of the requirement, exactly at it, and broken by one in-range result. This catches a wrong decode step, an off-by-one in firing and a counter that does not reset. Separate patterns cover code 0 with in-range data, a clear with and without a coincident strobe, runs far past saturation, bound and result changes with no strobe, and the pin under both enable values.

// File: rtl/thr_irq_pkg.sv
package thr_irq_pkg;

    // Run length needed by a persistence code (0 means every conversion).
    function automatic int unsigned pers_need_f(input int unsigned code,
                                                input int unsigned step);
        if (code == 0)
            return 0;
        else if (code < 4)
            return code;
        else
            return (code - 3) * step;
    endfunction

    // Largest run length any code can ask for.
    function automatic int unsigned pers_max_f(input int unsigned code_w,
                                               input int unsigned step);
        return pers_need_f((1 << code_w) - 1, step);
    endfunction

endpackage

// File: rtl/thr_range_cmp.sv
module thr_range_cmp #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] lo_bound,
    input  logic [DATA_W-1:0] hi_bound,
    output logic              below,
    output logic              above,
    output logic              out_of_range
);
    always_comb begin
        below        = value < lo_bound;
        above        = value > hi_bound;
        out_of_range = below | above;
    end
endmodule

// File: rtl/thr_pers_decode.sv
module thr_pers_decode
    import thr_irq_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int STEP   = 5,
    parameter int CNT_W  = 6
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  need,
    output logic              every
);
    always_comb begin
        need  = CNT_W'(pers_need_f(int'(code), STEP));
        every = (code == '0);
    end
endmodule

// File: rtl/thr_persist_ctr.sv
module thr_persist_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval,
    input  logic             oor,
    input  logic             every,
    input  logic [CNT_W-1:0] need,
    input  logic             clr,
    output logic             fire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_s;

    ctr_s             st_d, st_q;
    logic [CNT_W-1:0] inc;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        inc  = (st_q.cnt >= need) ? need : st_q.cnt + 1'b1;
        if (eval) begin
            if (every) begin
                fire     = 1'b1;
                st_d.cnt = '0;
            end else if (oor) begin
                st_d.cnt = inc;
                fire     = (inc == need);
            end else begin
                st_d.cnt = '0;
            end
        end else if (clr) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R9: an out-of-range run never climbs past the required count
    a_r9_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && oor && !every) |=> (st_q.cnt <= $past(need)));

    // R4: an in-range result ends the run
    a_r4_inrange_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !oor && !every) |=> (st_q.cnt == '0));

    // R8: with no strobe and no clear the run holds
    a_r8_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval && !clr) |=> $stable(st_q.cnt));

    // R5: a clear with no strobe zeroes the run
    a_r5_clr_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !eval) |=> (st_q.cnt == '0));
endmodule

// File: rtl/thr_irq_filter.sv
module thr_irq_filter
    import thr_irq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CODE_W = 4,
    parameter int STEP   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_value,
    input  logic [DATA_W-1:0] lo_bound,
    input  logic [DATA_W-1:0] hi_bound,
    input  logic [CODE_W-1:0] pers_code,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              stat_flag,
    output logic              irq_n
);
    localparam int MAX_NEED = pers_max_f(CODE_W, STEP);
    localparam int CNT_W    = $clog2(MAX_NEED + 1);

    typedef struct packed {
        logic flag;
    } flag_s;

    flag_s            st_d, st_q;
    logic             below, above, oor;
    logic [CNT_W-1:0] need;
    logic             every;
    logic             fire;

    thr_range_cmp #(.DATA_W(DATA_W)) u_cmp (
        .value        (conv_value),
        .lo_bound     (lo_bound),
        .hi_bound     (hi_bound),
        .below        (below),
        .above        (above),
        .out_of_range (oor)
    );

    thr_pers_decode #(.CODE_W(CODE_W), .STEP(STEP), .CNT_W(CNT_W)) u_dec (
        .code  (pers_code),
        .need  (need),
        .every (every)
    );

    thr_persist_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .eval  (conv_done),
        .oor   (oor),
        .every (every),
        .need  (need),
        .clr   (irq_clr),
        .fire  (fire)
    );

    // Set wins over clear; otherwise the flag holds.
    always_comb begin
        st_d = st_q;
        if (fire)
            st_d.flag = 1'b1;
        else if (irq_clr)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        stat_flag = st_q.flag;
        irq_n     = ~(st_q.flag & irq_en);
    end

    // R5: the flag is sticky until a clear
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flag && !irq_clr) |=> stat_flag);

    // R5: a lone clear drops the flag
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !conv_done) |=> !stat_flag);

    // R2: code 0 flags every conversion
    a_r2_every_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && every) |=> stat_flag);

    // R6: set beats a coincident clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && irq_clr && every) |=> stat_flag);

    // R8: the flag only rises after a strobe
    a_r8_rise_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_flag) |-> $past(conv_done));

    // R7: a disabled pin is released
    a_r7_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> irq_n);

    // R1: the compare sides never both hold when the window is ordered
    a_r1_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_bound <= hi_bound) |-> !(below && above));
endmodule

// File: tb/thr_irq_filter_bench.sv
module thr_irq_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] conv_value = '0;
    logic [15:0] lo_bound = '0;
    logic [15:0] hi_bound = '0;
    logic [3:0]  pers_code = '0;
    logic        irq_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic        stat_flag, irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit timed_out = 0;

    always #5 clk = ~clk;

    thr_irq_filter u_thr_irq_filter (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_value(conv_value),
        .lo_bound(lo_bound), .hi_bound(hi_bound), .pers_code(pers_code),
        .irq_en(irq_en), .irq_clr(irq_clr), .stat_flag(stat_flag), .irq_n(irq_n)
    );

    function automatic int need_of(input int code);
        if (code == 0) return 0;
        if (code < 4) return code;
        return 5 * (code - 3);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one strobe; outputs are checked at the following falling edge.
    task automatic conv(input logic [15:0] v, input logic clr);
        @(negedge clk);
        conv_value = v; conv_done = 1'b1; irq_clr = clr;
        @(negedge clk);
        conv_done = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic clear_only();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic run_all();
        // R10: reset state
        @(negedge clk);
        chk("R10 reset flag", stat_flag, 1'b0);
        chk("R10 reset pin", irq_n, 1'b1);
        rst_n = 1'b1;
        irq_en = 1'b1;

        // R1: compare sweep with code 1 over several windows
        pers_code = 4'd1;
        for (int w = 0; w < 4; w++) begin
            case (w)
                0: begin lo_bound = 16'd100; hi_bound = 16'd300; end
                1: begin lo_bound = 16'd0;   hi_bound = 16'd511; end
                2: begin lo_bound = 16'd256; hi_bound = 16'd256; end
                default: begin lo_bound = 16'd400; hi_bound = 16'd50; end
            endcase
            for (int v = 0; v < 512; v++) begin
                logic exp_o;
                exp_o = (v < int'(lo_bound)) || (v > int'(hi_bound));
                clear_only();
                conv(16'(v), 1'b0);
                chk("R1 window compare", stat_flag, exp_o);
            end
        end

        lo_bound = 16'd100; hi_bound = 16'd200;

        // R3/R4: every nonzero code
        for (int c = 1; c < 16; c++) begin
            int nd;
            nd = need_of(c);
            pers_code = 4'(c);
            clear_only();
            for (int k = 0; k < nd - 1; k++) conv(16'd50, 1'b0);
            chk("R3 one short", stat_flag, 1'b0);
            conv(16'd250, 1'b0);
            chk("R3 run complete", stat_flag, 1'b1);
            clear_only();
            chk("R5 lone clear", stat_flag, 1'b0);
            if (nd > 1) begin
                for (int k = 0; k < nd - 1; k++) conv(16'd99, 1'b0);
                conv(16'd150, 1'b0);
                for (int k = 0; k < nd - 1; k++) conv(16'd201, 1'b0);
                chk("R4 in-range breaks run", stat_flag, 1'b0);
                conv(16'd201, 1'b0);
                chk("R4 full new run sets", stat_flag, 1'b1);
            end
        end

        // R2: code 0 with in-range data
        pers_code = 4'd0;
        clear_only();
        conv(16'd150, 1'b0);
        chk("R2 every conversion", stat_flag, 1'b1);
        clear_only();
        conv(16'd100, 1'b1);
        chk("R6 set wins (code 0)", stat_flag, 1'b1);

        // R6: clear with a completing strobe, code 2
        pers_code = 4'd2;
        clear_only();
        conv(16'd10, 1'b0);
        conv(16'd10, 1'b1);
        chk("R6 set wins over clear", stat_flag, 1'b1);
        // clear with an in-range strobe: flag drops
        conv(16'd150, 1'b1);
        chk("R6 clear with no set", stat_flag, 1'b0);

        // R9: long run saturates; saturated strobe still sets with clear
        pers_code = 4'd3;
        clear_only();
        for (int k = 0; k < 80; k++) conv(16'd500, 1'b0);
        chk("R9 long run flagged", stat_flag, 1'b1);
        conv(16'd500, 1'b1);
        chk("R9 saturated run re-sets", stat_flag, 1'b1);

        // R5: lone clear zeroes the run
        clear_only();
        conv(16'd500, 1'b0);
        conv(16'd500, 1'b0);
        chk("R5 run zeroed by clear", stat_flag, 1'b0);
        conv(16'd500, 1'b0);
        chk("R5 run restarts", stat_flag, 1'b1);

        // R7: pin gating
        irq_en = 1'b0;
        #1;
        chk("R7 flag with enable off", stat_flag, 1'b1);
        chk("R7 pin released", irq_n, 1'b1);
        irq_en = 1'b1;
        #1;
        chk("R7 pin asserted", irq_n, 1'b0);
        clear_only();
        chk("R7 pin after clear", irq_n, 1'b1);

        // R8: no evaluation without strobe
        pers_code = 4'd1;
        @(negedge clk);
        conv_value = 16'd5;
        lo_bound = 16'd300; hi_bound = 16'd100;
        repeat (4) @(negedge clk);
        chk("R8 no strobe no flag", stat_flag, 1'b0);
        lo_bound = 16'd100; hi_bound = 16'd200;
        pers_code = 4'd2;
        conv(16'd5, 1'b0);
        @(negedge clk);
        conv_value = 16'd150;
        repeat (3) @(negedge clk);
        conv(16'd5, 1'b0);
        chk("R8 run held across idle", stat_flag, 1'b1);

        // R10: latency - visible right after the sampling edge
        clear_only();
        pers_code = 4'd0;
        @(negedge clk);
        conv_done = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 visible after edge", stat_flag, 1'b1);
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule